// File: doc/BRIEF.md
# Counting Partitioned Miss Filter

This block tells a load pipeline, before the cache tags have been looked up, that a requested line is certainly absent from the data cache. The line address, with the byte offset removed, is cut into equal slices. Each slice indexes its own small table of reference counters. A counter holds how many resident cache lines carry that slice value in that position. If any slice of a requested address finds a zero counter, no resident line can match, and the block reports a definite miss. If every slice finds a nonzero counter, the answer is only "may hit". False positives of this kind are allowed.

The cache controller keeps the counters up to date through the fill port. On each miss it gives the incoming line address and, when a line is evicted, the address of the victim. The counters chosen by the incoming line count up and the counters chosen by the victim count down, all in the same clock edge. Because eviction only decrements counters, no search of the remaining lines is needed. The query result is combinational on the current counter state, so one lookup costs no added cycles.

Top module: `cbf_miss_filter`

## Requirements
- R1: After reset every counter is zero, so every query address reports `qry_miss`=1.
- R2: Slice k of a line address is bits [k*PW +: PW], where PW = LINE_AW/NUM_PART and slice 0 is the least significant. With the defaults there are 4 slices of 4 bits each, and each slice indexes its own table of 16 counters.
- R3: `qry_miss` is 1 in the same cycle as `qry_addr` whenever at least one slice of `qry_addr` selects a counter holding zero.
- R4: `qry_miss` is 0 whenever every slice selects a nonzero counter. This holds even when the slices come from different resident lines (an allowed false positive).
- R5: A fill with `fill_valid`=1 increments the counter selected by each slice of `fill_addr`. The effect is visible on queries from the cycle after the sampling edge.
- R6: When `victim_valid`=1 in that fill, the counter selected by each slice of `victim_addr` is decremented in the same edge. A removed line that shares no slice value with any remaining line then reports a miss.
- R7: A counter that two resident lines share stays nonzero after one of the two lines is evicted.
- R8: When a slice of the incoming address and the same slice of the victim select the same counter, that counter keeps its value (net change zero).
- R9: When `victim_valid`=0 (cold fill), only increments are applied and `victim_addr` has no effect.
- R10: While `fill_valid`=0 no counter changes, whatever `victim_valid` and `victim_addr` hold.
- R11: Counters are wide enough to hold NUM_LINES. A slice value shared by many lines reports a miss only after its last line is evicted, and no counter wraps above its maximum or below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| qry_addr | input | LINE_AW | Line address to test |
| qry_miss | output | 1 | 1 = line certainly absent, 0 = line may be present |
| fill_valid | input | 1 | A cache fill is being recorded this cycle |
| fill_addr | input | LINE_AW | Line address being brought into the cache |
| victim_valid | input | 1 | A resident line is evicted by this fill |
| victim_addr | input | LINE_AW | Line address being evicted |

## Verification
The hardest case to reach from the ports is a counter that must pass back through one exactly, rather than zero. This happens when a slice value shared by many lines is drained one eviction at a time, or when a fill replaces a line with the same address, so that a double count would only show up on a later eviction. The stimulus fills one address many times and then evicts it the same number of times, querying before and after the final eviction. It also replaces a line with itself and then evicts it once, expecting a miss straight away. Shared-slice evictions and composed false-positive addresses are built from hand-chosen hex nibbles, so each slice's expected counter value is known.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  // Width needed to count from zero up to and including 'lines'.
  function automatic int cnt_width(input int lines);
    int w;
    w = 1;
    while ((1 << w) <= lines) w++;
    return w;
  endfunction
endpackage

// File: rtl/cbf_addr_split.sv
module cbf_addr_split #(
  parameter int LINE_AW  = 16,
  parameter int NUM_PART = 4,
  localparam int PW      = LINE_AW / NUM_PART
) (
  input  logic [LINE_AW-1:0]            addr,
  output logic [NUM_PART-1:0][PW-1:0]   idx
);
  // Slice k takes bits [k*PW +: PW]; slice 0 is the least significant.
  for (genvar k = 0; k < NUM_PART; k++) begin : g_slice
    assign idx[k] = addr[k*PW +: PW];
  end
endmodule

// File: rtl/cbf_counter_bank.sv
module cbf_counter_bank #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 7,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] qry_idx,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             dec_en,
  input  logic [IDX_W-1:0] dec_idx,
  output logic             qry_zero
);
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cnt_d [DEPTH];
  logic [DEPTH-1:0] inc_hit;
  logic [DEPTH-1:0] dec_hit;
  logic [DEPTH-1:0] upd_en;

  // Next-state: an entry hit by both sides keeps its value.
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      inc_hit[e] = inc_en && (inc_idx == IDX_W'(e));
      dec_hit[e] = dec_en && (dec_idx == IDX_W'(e));
      upd_en[e]  = inc_hit[e] ^ dec_hit[e];
      cnt_d[e]   = inc_hit[e] ? (cnt_q[e] + CNT_W'(1)) : (cnt_q[e] - CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (upd_en[e]) cnt_q[e] <= cnt_d[e];
      end
    end
  end

  assign qry_zero = (cnt_q[qry_idx] == '0);

  for (genvar e = 0; e < DEPTH; e++) begin : g_chk
    // R11: no decrement of an empty counter
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit[e] && !inc_hit[e]) |-> (cnt_q[e] != '0));
    // R11: no increment of a full counter
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit[e] && !dec_hit[e]) |-> (cnt_q[e] != '1));
    // R5: an incremented entry is nonzero afterwards
    p_inc_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit[e] && !dec_hit[e]) |=> (cnt_q[e] != '0));
    // R8: coinciding increment and decrement leave the entry unchanged
    p_net_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit[e] && dec_hit[e]) |=> $stable(cnt_q[e]));
    // R10: an entry selected by neither side keeps its value
    p_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_hit[e] && !dec_hit[e]) |=> $stable(cnt_q[e]));
  end
endmodule

// File: rtl/cbf_miss_filter.sv
module cbf_miss_filter #(
  parameter int LINE_AW   = 16,
  parameter int NUM_PART  = 4,
  parameter int NUM_LINES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_AW-1:0] qry_addr,
  output logic               qry_miss,
  input  logic               fill_valid,
  input  logic [LINE_AW-1:0] fill_addr,
  input  logic               victim_valid,
  input  logic [LINE_AW-1:0] victim_addr
);
  localparam int PW    = LINE_AW / NUM_PART;
  localparam int CNT_W = cbf_pkg::cnt_width(NUM_LINES);

  logic [NUM_PART-1:0][PW-1:0] qry_idx;
  logic [NUM_PART-1:0][PW-1:0] fill_idx;
  logic [NUM_PART-1:0][PW-1:0] vic_idx;
  logic [NUM_PART-1:0]         slice_zero;
  logic                        dec_en;

  // A victim only counts when a fill is recorded (R9, R10).
  assign dec_en = fill_valid && victim_valid;

  cbf_addr_split #(.LINE_AW(LINE_AW), .NUM_PART(NUM_PART)) u_split_qry (
    .addr(qry_addr), .idx(qry_idx));
  cbf_addr_split #(.LINE_AW(LINE_AW), .NUM_PART(NUM_PART)) u_split_fill (
    .addr(fill_addr), .idx(fill_idx));
  cbf_addr_split #(.LINE_AW(LINE_AW), .NUM_PART(NUM_PART)) u_split_vic (
    .addr(victim_addr), .idx(vic_idx));

  for (genvar k = 0; k < NUM_PART; k++) begin : g_bank
    cbf_counter_bank #(.IDX_W(PW), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .qry_idx  (qry_idx[k]),
      .inc_en   (fill_valid),
      .inc_idx  (fill_idx[k]),
      .dec_en   (dec_en),
      .dec_idx  (vic_idx[k]),
      .qry_zero (slice_zero[k])
    );
  end

  // R3/R4: any empty slice proves absence.
  assign qry_miss = |slice_zero;

  // R5: after a cold fill of the queried address, held stable, the query cannot miss
  p_fill_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !victim_valid && (fill_addr == qry_addr)) ##1 $stable(qry_addr)
      |-> !qry_miss);
endmodule

// File: tb/cbf_miss_filter_tb_top.sv
module cbf_miss_filter_tb_top;
  localparam int AW    = 16;
  localparam int LINES = 64;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] qry_addr;
  logic          qry_miss;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic          victim_valid;
  logic [AW-1:0] victim_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cbf_miss_filter #(.LINE_AW(AW), .NUM_PART(4), .NUM_LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .qry_addr(qry_addr), .qry_miss(qry_miss),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .victim_valid(victim_valid), .victim_addr(victim_addr));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic expect_q(input logic [AW-1:0] a, input logic exp, input string req);
    @(negedge clk);
    qry_addr = a;
    #1;
    checks++;
    if (qry_miss !== exp) begin
      errors++;
      $display("FAIL %s addr=%h qry_miss actual=%b expected=%b", req, a, qry_miss, exp);
    end
  endtask

  task automatic do_fill(input logic [AW-1:0] fa, input logic vv, input logic [AW-1:0] va);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = fa; victim_valid = vv; victim_addr = va;
    @(negedge clk);
    fill_valid = 1'b0; victim_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_q(16'h0000, 1'b1, "R1");
    expect_q(16'h1234, 1'b1, "R1");
    expect_q(16'hFFFF, 1'b1, "R1");
  endtask

  task automatic t_basic;
    do_fill(16'h1234, 1'b0, 16'h0000);
    expect_q(16'h1234, 1'b0, "R5");
    expect_q(16'h1235, 1'b1, "R3");
    expect_q(16'h5234, 1'b1, "R2");
    expect_q(16'h1334, 1'b1, "R2");
    do_fill(16'h5678, 1'b0, 16'h0000);
    expect_q(16'h1278, 1'b0, "R4");
    expect_q(16'h1638, 1'b0, "R4");
  endtask

  task automatic t_replace;
    // 0x1234 evicted by 0x1299: slices 3 and 2 coincide (R8), slices 1 and 0 drop to zero
    do_fill(16'h1299, 1'b1, 16'h1234);
    expect_q(16'h1234, 1'b1, "R6");
    expect_q(16'h1299, 1'b0, "R6");
    expect_q(16'h1239, 1'b1, "R6");
    expect_q(16'h1299, 1'b0, "R8");
  endtask

  task automatic t_shared;
    do_fill(16'h5ABC, 1'b0, 16'h0000);
    do_fill(16'h7DEF, 1'b1, 16'h5678);
    expect_q(16'h5678, 1'b1, "R6");
    expect_q(16'h5ABC, 1'b0, "R7");
    expect_q(16'h5DEF, 1'b0, "R7");
  endtask

  task automatic t_cold_ignores_victim;
    do_fill(16'h0000, 1'b0, 16'h1299);
    expect_q(16'h1299, 1'b0, "R9");
    expect_q(16'h0000, 1'b0, "R9");
  endtask

  task automatic t_idle;
    @(negedge clk);
    fill_valid = 1'b0; victim_valid = 1'b1; victim_addr = 16'h1299;
    @(negedge clk);
    @(negedge clk);
    victim_valid = 1'b0;
    expect_q(16'h1299, 1'b0, "R10");
  endtask

  task automatic t_self_replace;
    do_fill(16'h7DEF, 1'b1, 16'h7DEF);
    expect_q(16'h7DEF, 1'b0, "R8");
    do_fill(16'h0000, 1'b1, 16'h7DEF);
    expect_q(16'h7DEF, 1'b1, "R8");
  endtask

  task automatic t_deep_count;
    localparam int N = LINES - 8;
    for (int i = 0; i < N; i++) do_fill(16'h4444, 1'b0, 16'h0000);
    expect_q(16'h4444, 1'b0, "R11");
    for (int i = 0; i < N - 1; i++) do_fill(16'h0000, 1'b1, 16'h4444);
    expect_q(16'h4444, 1'b0, "R11");
    do_fill(16'h0000, 1'b1, 16'h4444);
    expect_q(16'h4444, 1'b1, "R11");
    expect_q(16'h0000, 1'b0, "R11");
  endtask

  initial begin
    rst_n = 1'b0; qry_addr = '0; fill_valid = 1'b0; fill_addr = '0;
    victim_valid = 1'b0; victim_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_replace;
    t_shared;
    t_cold_ignores_victim;
    t_idle;
    t_self_replace;
    t_deep_count;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule